// File: doc/BRIEF.md
# Row-Scan Timing Generator for a Dot-Matrix LCD

This block produces the row-scan timing that walks a one-hot select pattern down the common (row) electrodes of a dot-matrix LCD. As the timing master it divides an oscillator tick stream into a line clock, a one-line frame marker, an inversion toggle that flips once per frame, and a pair of two-phase clocks for the column drivers. As a timing slave it produces none of these. Instead it follows a line clock and an inversion signal received from a master, and it passes the select pattern along a serial chain.

A one-hot pattern travels through a row-select shift register of `STAGES` stages. The pattern moves on the rising or the falling line-clock edge, as configured, and in either direction. In master mode the frame marker feeds the register, so one select bit enters per frame. In slave mode the bit arrives on whichever chain pin holds the input role. The analog oscillator is modelled as a one-cycle tick enable. The number of ticks per line is a parameter. A rate input halves that count for the slower oscillator, so the frame rate stays the same.

Top module: `com_scan_timing`

## Requirements
- R1: In master mode one line lasts P oscillator ticks. `line_clk_o` is low for tick positions 0 to P/2-1 of the line and high for positions P/2 to P-1.
- R2: P equals `LINE_DIV` when `rate_fast` is 1 and `LINE_DIV/2` when `rate_fast` is 0.
- R3: The `duty_sel` code sets the lines per frame: 2'b00 gives 48, 2'b01 gives 64, 2'b10 gives 96 and 2'b11 gives 128. `frame_o` is high for the whole of line 0 and low on every other line.
- R4: `inv_o` is 0 after reset. In master mode it inverts each time the line count wraps to line 0.
- R5: In master mode `phase_a_o` is low during the first quarter of each line and `phase_b_o` is low during the third quarter. Both are high otherwise, so they are never low together.
- R6: In master mode the register input is `frame_o`. Exactly one 1 enters at the selected edge that falls within line 0 of each frame.
- R7: With `scan_up`=1 a shift moves `com_o[i]` to `com_o[i+1]` and loads the input into `com_o[0]`. With `scan_up`=0 a shift moves `com_o[i]` to `com_o[i-1]` and loads the input into `com_o[STAGES-1]`.
- R8: With `shift_on_rise`=1 the register shifts once per rising line-clock edge, and with 0 once per falling edge. In master mode the shift takes effect one clock after the line-clock output changes.
- R9: In slave mode `line_clk_o` and `frame_o` stay 0, both phase outputs stay 1 and the tick counters do not advance. The line clock comes from `ext_line_clk_i` through a two-stage synchronizer, and `inv_o` follows `ext_inv_i` through the same depth.
- R10: `chain_a_o` always carries `com_o[0]` and `chain_b_o` always carries `com_o[STAGES-1]`. In master mode both enables are 1. In slave mode with `scan_up`=1, pin A is the input (`chain_a_oe`=0, `chain_b_oe`=1). With `scan_up`=0 the roles swap. In slave mode the register input is the input-role pin.
- R11: Reset clears the register, the tick and line counters and the inversion state. A master therefore leaves reset on line 0, tick 0.
- R12: The master counters advance only in cycles where `osc_en` is 1. With `osc_en` low, every timing output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator tick enable |
| is_master | input | 1 | 1 = generate timing, 0 = follow external timing |
| rate_fast | input | 1 | 1 = fast oscillator (LINE_DIV ticks per line), 0 = half |
| duty_sel | input | 2 | Lines-per-frame code |
| scan_up | input | 1 | Shift direction, 1 = toward higher index |
| shift_on_rise | input | 1 | 1 = shift on rising line-clock edge, 0 = falling |
| ext_line_clk_i | input | 1 | Line clock from a master (slave mode) |
| ext_inv_i | input | 1 | Inversion signal from a master (slave mode) |
| chain_a_i | input | 1 | Chain pin A input value |
| chain_b_i | input | 1 | Chain pin B input value |
| line_clk_o | output | 1 | Generated line clock |
| frame_o | output | 1 | Frame marker, high during line 0 |
| inv_o | output | 1 | Frame inversion signal |
| phase_a_o | output | 1 | Two-phase clock A for column drivers |
| phase_b_o | output | 1 | Two-phase clock B for column drivers |
| chain_a_o | output | 1 | Chain pin A output value |
| chain_a_oe | output | 1 | Chain pin A output enable |
| chain_b_o | output | 1 | Chain pin B output value |
| chain_b_oe | output | 1 | Chain pin B output enable |
| com_o | output | STAGES | Row-select register contents |

## Verification
On every cycle, the embedded properties check that the two phase clocks never go low together and that the tick counter wraps at the end of a line. They also check that the line count returns to line 0 when a frame ends, and that inversion changes only at line 0, tick 0. Further properties confirm that idle ticks and idle shift steps leave the state untouched, that each shift loads the input into the end stage matching the direction, and that in slave mode exactly one chain pin drives. Some behaviour only the directed scenarios can show. These are the exact line-clock and phase waveforms at both rates, and the frame length for each duty code. They are also the precise cycle on which a bit enters for each edge choice, the settling latency through the synchronizer, and the propagation of a bit from one chain pin to the other across the full register.

// File: rtl/com_scan_pkg.sv
package com_scan_pkg;

  typedef enum logic [1:0] {
    DUTY_48  = 2'b00,
    DUTY_64  = 2'b01,
    DUTY_96  = 2'b10,
    DUTY_128 = 2'b11
  } duty_e;

  localparam int LINE_IDX_W = 7;

  function automatic logic [LINE_IDX_W:0] lines_per_frame(input duty_e d);
    case (d)
      DUTY_48:  return 8'd48;
      DUTY_64:  return 8'd64;
      DUTY_96:  return 8'd96;
      default:  return 8'd128;
    endcase
  endfunction

endpackage

// File: rtl/com_line_timer.sv
module com_line_timer
  import com_scan_pkg::*;
#(
  parameter int LINE_DIV = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  fast,
  input  duty_e duty,
  output logic  line_clk,
  output logic  frame,
  output logic  phase_a,
  output logic  phase_b,
  output logic  inv
);

  localparam int TICK_W = $clog2(LINE_DIV);
  localparam int PER_W  = TICK_W + 1;
  localparam logic [PER_W-1:0] PER_FAST = PER_W'(LINE_DIV);
  localparam logic [PER_W-1:0] PER_SLOW = PER_W'(LINE_DIV / 2);

  logic [TICK_W-1:0]     tick_q, tick_d;
  logic [LINE_IDX_W-1:0] line_q, line_d;
  logic                  inv_q, inv_d;

  logic [PER_W-1:0]      period, quarter, q2, q3, tick_x;
  logic [LINE_IDX_W:0]   n_lines;
  logic                  last_tick, last_line;

  always_comb begin
    period    = fast ? PER_FAST : PER_SLOW;
    quarter   = period >> 2;
    q2        = quarter << 1;
    q3        = q2 + quarter;
    tick_x    = PER_W'(tick_q);
    n_lines   = lines_per_frame(duty);
    last_tick = (tick_x >= (period - 1'b1));
    last_line = ({1'b0, line_q} >= (n_lines - 1'b1));
  end

  always_comb begin
    tick_d = tick_q;
    line_d = line_q;
    inv_d  = inv_q;
    if (run) begin
      if (last_tick) begin
        tick_d = '0;
        if (last_line) begin
          line_d = '0;
          inv_d  = ~inv_q;
        end else begin
          line_d = line_q + 1'b1;
        end
      end else begin
        tick_d = tick_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      line_q <= '0;
      inv_q  <= 1'b0;
    end else begin
      tick_q <= tick_d;
      line_q <= line_d;
      inv_q  <= inv_d;
    end
  end

  always_comb begin
    line_clk = (tick_x >= (period >> 1));
    frame    = (line_q == '0);
    phase_a  = (tick_x >= quarter);
    phase_b  = !((tick_x >= q2) && (tick_x < q3));
    inv      = inv_q;
  end

  // R1: the end of a line returns the tick position to zero
  p_tick_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && last_tick) |=> (tick_q == '0));

  // R3: the last line of a frame is followed by line 0
  p_frame_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && last_tick && last_line) |=> frame);

  // R4: inversion changes only at the very start of a frame
  p_inv_frame_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(inv_q) |-> ((line_q == '0) && (tick_q == '0)));

  // R5: the two phase clocks are never low together
  p_phase_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_a || phase_b));

  // R12: without a tick the counters hold
  p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(tick_q) && $stable(line_q)));

endmodule

// File: rtl/com_line_edge.sv
module com_line_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic int_clk,
  input  logic ext_clk,
  input  logic ext_inv,
  input  logic on_rise,
  output logic step,
  output logic inv_ext
);

  logic [SYNC_STAGES-1:0] clk_sync_q, clk_sync_d;
  logic [SYNC_STAGES-1:0] inv_sync_q, inv_sync_d;
  logic                   lc, lc_q;
  logic                   rise, fall;

  always_comb begin
    clk_sync_d = {clk_sync_q[SYNC_STAGES-2:0], ext_clk};
    inv_sync_d = {inv_sync_q[SYNC_STAGES-2:0], ext_inv};
    lc         = master ? int_clk : clk_sync_q[SYNC_STAGES-1];
    rise       = lc & ~lc_q;
    fall       = ~lc & lc_q;
    step       = on_rise ? rise : fall;
    inv_ext    = inv_sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync_q <= '0;
      inv_sync_q <= '0;
      lc_q       <= 1'b0;
    end else begin
      clk_sync_q <= clk_sync_d;
      inv_sync_q <= inv_sync_d;
      lc_q       <= lc;
    end
  end

  // R8: a selected edge is never reported on two cycles in a row
  p_single_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);

endmodule

// File: rtl/com_scan_reg.sv
module com_scan_reg #(
  parameter int STAGES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              up,
  input  logic              din,
  output logic [STAGES-1:0] com
);

  logic [STAGES-1:0] com_q;
  wire  [STAGES-1:0] com_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    wire from_low;
    wire from_high;
    if (i == 0) begin : g_low_end
      assign from_low = din;
    end else begin : g_low_mid
      assign from_low = com_q[i-1];
    end
    if (i == STAGES - 1) begin : g_high_end
      assign from_high = din;
    end else begin : g_high_mid
      assign from_high = com_q[i+1];
    end
    assign com_d[i] = step ? (up ? from_low : from_high) : com_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) com_q <= '0;
    else        com_q <= com_d;
  end

  assign com = com_q;

  // R7: no step, no movement
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(com_q));

  // R7: upward shift loads the input into the lowest stage
  p_enter_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && up) |=> (com_q[0] == $past(din)));

  // R7: downward shift loads the input into the highest stage
  p_enter_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !up) |=> (com_q[STAGES-1] == $past(din)));

endmodule

// File: rtl/com_scan_timing.sv
module com_scan_timing
  import com_scan_pkg::*;
#(
  parameter int LINE_DIV    = 16,
  parameter int STAGES      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              is_master,
  input  logic              rate_fast,
  input  logic [1:0]        duty_sel,
  input  logic              scan_up,
  input  logic              shift_on_rise,
  input  logic              ext_line_clk_i,
  input  logic              ext_inv_i,
  input  logic              chain_a_i,
  input  logic              chain_b_i,
  output logic              line_clk_o,
  output logic              frame_o,
  output logic              inv_o,
  output logic              phase_a_o,
  output logic              phase_b_o,
  output logic              chain_a_o,
  output logic              chain_a_oe,
  output logic              chain_b_o,
  output logic              chain_b_oe,
  output logic [STAGES-1:0] com_o
);

  logic t_line_clk, t_frame, t_phase_a, t_phase_b, t_inv;
  logic step, inv_ext, din;

  com_line_timer #(.LINE_DIV(LINE_DIV)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (osc_en & is_master),
    .fast     (rate_fast),
    .duty     (duty_e'(duty_sel)),
    .line_clk (t_line_clk),
    .frame    (t_frame),
    .phase_a  (t_phase_a),
    .phase_b  (t_phase_b),
    .inv      (t_inv)
  );

  com_line_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .master  (is_master),
    .int_clk (t_line_clk),
    .ext_clk (ext_line_clk_i),
    .ext_inv (ext_inv_i),
    .on_rise (shift_on_rise),
    .step    (step),
    .inv_ext (inv_ext)
  );

  always_comb begin
    if (is_master) din = t_frame;
    else           din = scan_up ? chain_a_i : chain_b_i;
  end

  com_scan_reg #(.STAGES(STAGES)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .up    (scan_up),
    .din   (din),
    .com   (com_o)
  );

  always_comb begin
    line_clk_o = is_master & t_line_clk;
    frame_o    = is_master & t_frame;
    phase_a_o  = ~is_master | t_phase_a;
    phase_b_o  = ~is_master | t_phase_b;
    inv_o      = is_master ? t_inv : inv_ext;
    chain_a_o  = com_o[0];
    chain_b_o  = com_o[STAGES-1];
    chain_a_oe = is_master | ~scan_up;
    chain_b_oe = is_master | scan_up;
  end

  // R10: in slave mode exactly one chain pin drives
  p_chain_roles_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> $countones({chain_a_oe, chain_b_oe}) == 1);

  // R9: a slave never emits a frame marker or line clock
  p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> (!line_clk_o && !frame_o && phase_a_o && phase_b_o));

endmodule

// File: tb/com_scan_timing_test.sv
module com_scan_timing_test;

  localparam int CLK_PERIOD = 10;
  localparam int LDIV       = 16;
  localparam int NST        = 64;

  logic clk = 1'b0;
  logic rst_n, osc_en, is_master, rate_fast, scan_up, shift_on_rise;
  logic [1:0] duty_sel;
  logic ext_line_clk_i, ext_inv_i, chain_a_i, chain_b_i;
  logic line_clk_o, frame_o, inv_o, phase_a_o, phase_b_o;
  logic chain_a_o, chain_a_oe, chain_b_o, chain_b_oe;
  logic [NST-1:0] com_o;

  int total = 0;
  int bad   = 0;
  int t_now = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  com_scan_timing #(.LINE_DIV(LDIV), .STAGES(NST), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .is_master(is_master),
    .rate_fast(rate_fast), .duty_sel(duty_sel), .scan_up(scan_up),
    .shift_on_rise(shift_on_rise), .ext_line_clk_i(ext_line_clk_i),
    .ext_inv_i(ext_inv_i), .chain_a_i(chain_a_i), .chain_b_i(chain_b_i),
    .line_clk_o(line_clk_o), .frame_o(frame_o), .inv_o(inv_o),
    .phase_a_o(phase_a_o), .phase_b_o(phase_b_o),
    .chain_a_o(chain_a_o), .chain_a_oe(chain_a_oe),
    .chain_b_o(chain_b_o), .chain_b_oe(chain_b_oe), .com_o(com_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at tick %0d: actual=%h expected=%h", tag, t_now, act, exp);
    end
  endtask

  task automatic setup(input logic m, input logic fast, input logic [1:0] d,
                       input logic up, input logic rise);
    @(negedge clk);
    rst_n = 1'b0;
    is_master = m; rate_fast = fast; duty_sel = d;
    scan_up = up; shift_on_rise = rise; osc_en = 1'b1;
    ext_line_clk_i = 1'b0; ext_inv_i = 1'b0; chain_a_i = 1'b0; chain_b_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_now = 0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    t_now += n;
  endtask

  task automatic go_to(input int t);
    if (t > t_now) step(t - t_now);
  endtask

  task automatic t_reset;
    setup(1'b1, 1'b1, 2'b00, 1'b1, 1'b1);
    chk("R11 com cleared", com_o, 64'h0);
    chk("R11 inv cleared", 64'(inv_o), 64'h0);
    chk("R11 frame at line 0", 64'(frame_o), 64'h1);
    chk("R11 line clock low", 64'(line_clk_o), 64'h0);
    chk("R11 phase a low at tick 0", 64'(phase_a_o), 64'h0);
    chk("R10 master oe", 64'({chain_a_oe, chain_b_oe}), 64'h3);
  endtask

  task automatic t_line_shape;
    setup(1'b1, 1'b1, 2'b00, 1'b1, 1'b1);
    for (int t = 0; t < LDIV; t++) begin
      go_to(t);
      chk("R1 line clock", 64'(line_clk_o), 64'(t >= LDIV/2));
      chk("R5 phase a", 64'(phase_a_o), 64'(t >= LDIV/4));
      chk("R5 phase b", 64'(phase_b_o), 64'(!(t >= LDIV/2 && t < 3*LDIV/4)));
    end
    go_to(LDIV);
    chk("R1 next line starts low", 64'(line_clk_o), 64'h0);
  endtask

  task automatic t_slow_rate;
    setup(1'b1, 1'b0, 2'b00, 1'b1, 1'b1);
    for (int t = 0; t < LDIV/2; t++) begin
      go_to(t);
      chk("R2 slow line clock", 64'(line_clk_o), 64'(t >= LDIV/4));
      chk("R2 slow phase a", 64'(phase_a_o), 64'(t >= LDIV/8));
    end
    go_to(LDIV/2);
    chk("R2 slow period wraps", 64'(line_clk_o), 64'h0);
    chk("R2 slow still frame line 1", 64'(frame_o), 64'h0);
  endtask

  task automatic t_duty;
    int n;
    for (int d = 0; d < 4; d++) begin
      n = (d == 0) ? 48 : (d == 1) ? 64 : (d == 2) ? 96 : 128;
      setup(1'b1, 1'b1, 2'(d), 1'b1, 1'b1);
      go_to(LDIV);
      chk("R3 frame low on line 1", 64'(frame_o), 64'h0);
      go_to(n*LDIV - 1);
      chk("R3 frame low on last line", 64'(frame_o), 64'h0);
      chk("R4 inv before wrap", 64'(inv_o), 64'h0);
      go_to(n*LDIV);
      chk("R3 frame back after n lines", 64'(frame_o), 64'h1);
      chk("R4 inv toggles at frame", 64'(inv_o), 64'h1);
    end
  endtask

  task automatic t_inject_rise;
    setup(1'b1, 1'b1, 2'b00, 1'b1, 1'b1);
    go_to(LDIV/2);
    chk("R8 no shift same cycle as rise", com_o, 64'h0);
    go_to(LDIV/2 + 1);
    chk("R6 bit enters on rise", com_o, 64'h1);
    go_to(3*LDIV + LDIV/2 + 2);
    chk("R7 up after four shifts", com_o, 64'h8);
    chk("R10 chain b idle", 64'(chain_b_o), 64'h0);
    setup(1'b1, 1'b1, 2'b00, 1'b0, 1'b1);
    go_to(LDIV/2 + 1);
    chk("R7 down entry at top", com_o, 64'h8000_0000_0000_0000);
    chk("R10 chain b carries top", 64'(chain_b_o), 64'h1);
    chk("R10 chain a carries bottom", 64'(chain_a_o), 64'h0);
    go_to(3*LDIV + LDIV/2 + 2);
    chk("R7 down after four shifts", com_o, 64'h1000_0000_0000_0000);
  endtask

  task automatic t_inject_fall;
    setup(1'b1, 1'b1, 2'b00, 1'b1, 1'b0);
    go_to(48*LDIV);
    chk("R8 falling mode empty first frame", com_o, 64'h0);
    go_to(48*LDIV + 1);
    chk("R6 bit enters on fall into line 0", com_o, 64'h1);
    go_to(50*LDIV + 1);
    chk("R8 two further falls", com_o, 64'h4);
  endtask

  task automatic t_osc_gate;
    setup(1'b1, 1'b1, 2'b00, 1'b1, 1'b1);
    go_to(LDIV/4 - 1);
    osc_en = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R12 phase a holds", 64'(phase_a_o), 64'h0);
    chk("R12 line clock holds", 64'(line_clk_o), 64'h0);
    osc_en = 1'b1;
    step(1);
    chk("R12 advances on tick", 64'(phase_a_o), 64'h1);
  endtask

  task automatic t_slave_up;
    setup(1'b0, 1'b1, 2'b00, 1'b1, 1'b1);
    chk("R9 slave line clock", 64'(line_clk_o), 64'h0);
    chk("R9 slave frame", 64'(frame_o), 64'h0);
    chk("R9 slave phases", 64'({phase_a_o, phase_b_o}), 64'h3);
    chk("R10 slave up oe", 64'({chain_a_oe, chain_b_oe}), 64'h1);
    chain_a_i = 1'b1; ext_line_clk_i = 1'b1;
    step(4);
    chk("R9 slave rise shifts chain a", com_o, 64'h1);
    chain_a_i = 1'b0; ext_line_clk_i = 1'b0;
    step(4);
    chk("R8 slave fall ignored in rise mode", com_o, 64'h1);
    ext_line_clk_i = 1'b1; ext_inv_i = 1'b1;
    step(4);
    chk("R7 slave second shift", com_o, 64'h2);
    chk("R9 inv follows master", 64'(inv_o), 64'h1);
    chk("R9 slave still quiet", 64'(frame_o), 64'h0);
  endtask

  task automatic t_slave_down;
    setup(1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    chk("R10 slave down oe", 64'({chain_a_oe, chain_b_oe}), 64'h2);
    chain_b_i = 1'b1; ext_line_clk_i = 1'b1;
    step(4);
    chk("R8 rise ignored in fall mode", com_o, 64'h0);
    ext_line_clk_i = 1'b0;
    step(4);
    chk("R10 chain b enters top", com_o, 64'h8000_0000_0000_0000);
    chain_b_i = 1'b0;
    for (int k = 0; k < NST-1; k++) begin
      ext_line_clk_i = 1'b1; step(4);
      ext_line_clk_i = 1'b0; step(4);
    end
    chk("R7 bit reached bottom", com_o, 64'h1);
    chk("R10 chain a drives bit out", 64'(chain_a_o), 64'h1);
  endtask

  initial begin
    rst_n = 1'b0; osc_en = 1'b0; is_master = 1'b1; rate_fast = 1'b1;
    duty_sel = 2'b00; scan_up = 1'b1; shift_on_rise = 1'b1;
    ext_line_clk_i = 1'b0; ext_inv_i = 1'b0; chain_a_i = 1'b0; chain_b_i = 1'b0;
    t_reset();
    t_line_shape();
    t_slow_rate();
    t_duty();
    t_inject_rise();
    t_inject_fall();
    t_osc_gate();
    t_slave_up();
    t_slave_down();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule